// File: doc/BRIEF.md
# Scrambling NRZI Video Serializer

This block converts a stream of 10-bit parallel video words into one serial bit stream running at ten times the word rate. It runs entirely on the bit-rate clock. A load strobe, pulsed once every ten clocks, captures the next word. The bits then leave least significant bit first.

Each serial bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. It is then converted from NRZ to NRZI with the x + 1 polynomial, so a scrambled 1 flips the line level and a 0 keeps it. A bypass input sends the raw serialized bits straight to the output. A clear input empties the scrambler history. When the PLL lock indicator is low, the output is forced low.

The clock multiplier, the PLL itself and the analog line driver sit outside the block. The bench supplies the bit clock and the load strobe directly.

Top module: `vid_serializer`

## Requirements
- R1: On a clock edge where `load` is high, `word` is captured. Bit k of that word (bit 0 first) determines `sdo` after the (k+1)-th rising edge that follows the load edge. Bits 1 to 9 therefore leave one per clock.
- R2: With `pll_locked` high and `bypass` high, `sdo` after an edge equals the raw serial bit that was current before that edge, with no scrambling and no NRZI coding.
- R3: The scrambled bit is computed as the serial data bit XOR the scrambled bit from 4 bit periods earlier XOR the scrambled bit from 9 bit periods earlier. From an empty history, a single 1 followed by zeros scrambles to 1,0,0,0,1,0,0,0,1,1.
- R4: With `pll_locked` high and `bypass` low, `sdo` toggles on an edge exactly when the scrambled bit for that edge is 1.
- R5: When `sdo` is NRZI-decoded and then descrambled with x^9 + x^4 + 1, the result matches the original serial data bits. This holds once 9 or more coded bits have passed since the last clear, mute or bypass period.
- R6: A high `scr_clear` at an edge empties the scrambler history, so the following bits scramble as if from an all-zero history.
- R7: While `pll_locked` is low, `sdo` is 0 after every edge and the NRZI level is held at 0. The first coded bit after relock therefore starts from level 0.
- R8: While `rst_n` is low, `sdo` is 0 and the shift register and scrambler history are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Word capture strobe, high one clock in ten |
| word | input | 10 | Parallel data word, bit 0 sent first |
| bypass | input | 1 | High sends raw bits, skipping the scrambler and NRZI coder |
| scr_clear | input | 1 | High empties the scrambler history |
| pll_locked | input | 1 | Lock indicator; low mutes the output |
| sdo | output | 1 | Serial data output |

## Verification
The bench feeds an impulse word into a freshly cleared scrambler and checks the decoded transitions against the known impulse response. A design with wrong taps or a wrong history depth produces the 1s in the wrong places.

A running NRZI decoder and descrambler on the output must recover every data bit. A design that inverted the NRZI sense or scrambled the wrong signal would fail this recovery. So would one that fed the raw bit instead of the scrambled bit back into its history.

The bench also drops lock in the middle of a word and toggles bypass in the middle of a stream. It compares against a behavioural model on every clock, so a design that kept its NRZI level through a mute, or shifted bits out in the wrong order, shows a mismatch on the first affected bit.

// File: rtl/vid_ser_pkg.sv
`timescale 1ns/1ps
package vid_ser_pkg;

  typedef enum logic [1:0] {
    MODE_MUTE  = 2'd0,
    MODE_RAW   = 2'd1,
    MODE_CODED = 2'd2
  } line_mode_e;

  // Lock has priority over bypass.
  function automatic line_mode_e pick_mode(input logic locked, input logic raw_sel);
    if (!locked)      return MODE_MUTE;
    else if (raw_sel) return MODE_RAW;
    else              return MODE_CODED;
  endfunction

  // x + 1 line coding: a one flips the level.
  function automatic logic nrzi_step(input logic level, input logic b);
    return level ^ b;
  endfunction

endpackage

// File: rtl/vid_ser_piso.sv
`timescale 1ns/1ps
module vid_ser_piso #(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              bit_o
);
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= {1'b0, shreg[WORD_W-1:1]};
  end

  assign bit_o = shreg[0];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (bit_o == $past(word[0]))); // R1
  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (bit_o == $past(shreg[1]))); // R1
endmodule

// File: rtl/vid_ser_scrambler.sv
`timescale 1ns/1ps
module vid_ser_scrambler #(
  parameter int HIST_LEN = 9,
  parameter int TAP_NEAR = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic dout
);
  logic [HIST_LEN-1:0] hist;   // hist[0] is the most recent scrambled bit

  assign dout = din ^ hist[TAP_NEAR-1] ^ hist[HIST_LEN-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) hist <= '0;
    else               hist <= {hist[HIST_LEN-2:0], dout};
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (hist == '0)); // R6
  AST_HIST_FEED: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (hist[0] == $past(dout))); // R3
endmodule

// File: rtl/vid_ser_line_coder.sv
`timescale 1ns/1ps
module vid_ser_line_coder
  import vid_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  line_mode_e mode,
  input  logic       raw,
  input  logic       scr,
  output logic       sdo
);
  logic level;

  always_ff @(posedge clk) begin
    if (!rst_n) level <= 1'b0;
    else begin
      case (mode)
        MODE_RAW:   level <= raw;
        MODE_CODED: level <= nrzi_step(level, scr);
        default:    level <= 1'b0;
      endcase
    end
  end

  assign sdo = level;

  AST_MUTE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MUTE) |=> (sdo == 1'b0)); // R7
  AST_RAW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_RAW) |=> (sdo == $past(raw))); // R2
  AST_NRZI_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CODED) |=> ((sdo != $past(sdo)) == $past(scr))); // R4
endmodule

// File: rtl/vid_serializer.sv
`timescale 1ns/1ps
module vid_serializer
  import vid_ser_pkg::*;
#(
  parameter int WORD_W   = 10,
  parameter int HIST_LEN = 9,
  parameter int TAP_NEAR = 4
) (
  input  logic              bit_clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              bypass,
  input  logic              scr_clear,
  input  logic              pll_locked,
  output logic              sdo
);
  logic       nrz_bit;
  logic       scr_bit;
  line_mode_e mode;

  assign mode = pick_mode(pll_locked, bypass);

  vid_ser_piso #(.WORD_W(WORD_W)) piso_i (
    .clk(bit_clk), .rst_n(rst_n), .load(load), .word(word), .bit_o(nrz_bit)
  );

  vid_ser_scrambler #(.HIST_LEN(HIST_LEN), .TAP_NEAR(TAP_NEAR)) scr_i (
    .clk(bit_clk), .rst_n(rst_n), .clr(scr_clear), .din(nrz_bit), .dout(scr_bit)
  );

  vid_ser_line_coder coder_i (
    .clk(bit_clk), .rst_n(rst_n), .mode(mode), .raw(nrz_bit), .scr(scr_bit), .sdo(sdo)
  );

  AST_RESET_LOW: assert property (@(posedge bit_clk)
    !rst_n |=> (sdo == 1'b0)); // R8
endmodule

// File: tb/vid_serializer_tb_top.sv
`timescale 1ns/1ps
module vid_serializer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [9:0] word = '0;
  logic       bypass = 1'b0;
  logic       scr_clear = 1'b0;
  logic       locked = 1'b0;
  logic       sdo;

  int tests = 0;
  int fails = 0;
  int ph = 0;
  bit finished = 0;

  // reference model state
  bit m_q[$];
  bit m_h[$];
  bit m_out = 0;
  bit m_b = 0;

  // running descrambler on the line
  bit       prev_sdo = 0;
  bit [8:0] dh = '0;
  int       run = 0;

  always #2.5 clk = ~clk;

  vid_serializer dut_i (
    .bit_clk(clk), .rst_n(rst_n), .load(load), .word(word), .bypass(bypass),
    .scr_clear(scr_clear), .pll_locked(locked), .sdo(sdo)
  );

  always @(posedge clk) begin
    bit b, s;
    if (!rst_n) begin
      m_q.delete(); m_h.delete();
      repeat (9) m_h.push_back(1'b0);
      m_out = 0; m_b = 0;
    end else begin
      b = (m_q.size() > 0) ? m_q[0] : 1'b0;
      if (m_q.size() > 0) void'(m_q.pop_front());
      if (load) begin
        m_q.delete();
        for (int i = 0; i < 10; i++) m_q.push_back(word[i]);
      end
      s = b ^ m_h[3] ^ m_h[8];
      if (scr_clear) begin
        for (int i = 0; i < 9; i++) m_h[i] = 1'b0;
      end else begin
        m_h.push_front(s); void'(m_h.pop_back());
      end
      if (!locked)     m_out = 0;
      else if (bypass) m_out = b;
      else             m_out = m_out ^ s;
      m_b = b;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic [9:0] w, input logic clr);
    bit d, desc;
    string tag;
    load = (ph == 0); word = w; scr_clear = clr;
    ph = (ph + 1) % 10;
    @(posedge clk); @(negedge clk);
    tag = !locked ? "R7" : (bypass ? "R2" : "R4");
    check(sdo === m_out, tag, sdo, m_out);
    d = sdo ^ prev_sdo; prev_sdo = sdo;
    desc = d ^ dh[3] ^ dh[8];
    dh = {dh[7:0], d};
    if (locked && !bypass && !clr) run++; else run = 0;
    if (run > 10) check(desc == m_b, "R5", desc, m_b);
  endtask

  task automatic align();
    while (ph != 0) tick($urandom, 1'b0);
  endtask

  task automatic rand_ticks(input int n);
    for (int i = 0; i < n; i++) tick($urandom, 1'b0);
  endtask

  task automatic serial_order(input logic [9:0] w);
    align();
    tick(w, 1'b0);
    for (int k = 0; k < 10; k++) begin
      tick($urandom, 1'b0);
      check(sdo == w[k], "R1", sdo, w[k]);
    end
  endtask

  task automatic impulse(input string req);
    bit exp_s[10] = '{1,0,0,0,1,0,0,0,1,1};
    bit p;
    align();
    tick(10'h001, 1'b1);
    p = sdo;
    for (int k = 0; k < 10; k++) begin
      tick(10'h000, 1'b0);
      check((sdo ^ p) == exp_s[k], req, sdo ^ p, exp_s[k]);
      p = sdo;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(sdo == 1'b0, "R8", sdo, 0);  // R8 output low in reset
    rst_n = 1'b1; locked = 1'b1; bypass = 1'b1; ph = 0;
    serial_order(10'h2C5);             // R1 and R2
    serial_order(10'h17A);
    rand_ticks(40);
    bypass = 1'b0;
    impulse("R3");
    rand_ticks(100);
    impulse("R6");                     // R6 clear after random history
    rand_ticks(200);                   // R5 recovery
    align(); rand_ticks(3);
    locked = 1'b0; rand_ticks(25);     // R7 muted mid-word
    locked = 1'b1; rand_ticks(60);
    bypass = 1'b1; rand_ticks(17);
    bypass = 1'b0; rand_ticks(100);
    tick($urandom, 1'b1); rand_ticks(50);
    rst_n = 1'b0; @(negedge clk); @(negedge clk);
    check(sdo == 1'b0, "R8", sdo, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule